// File: doc/BRIEF.md
# SPI EEPROM Status Register Front-End

This block is the serial slave front end that a small SPI EEPROM presents for its status register. It follows SPI mode 0: the host pulls chip select low, and the block takes a bit from the serial input on each rising serial clock edge. When it returns data, it changes the serial output on the falling edge. The block recognises four opcodes: read status (0x05), set write enable (0x06), clear write enable (0x04) and write status (0x01). It holds the write-enable latch, two block-protect bits and a protect-enable bit. It reports a write-in-progress flag. That flag is the OR of an external busy input from the array write engine and an internal timed cycle that a successful status write starts.

All serial inputs are synchronised into the system clock domain through two flops and then edge detected. Because of this, every serial clock phase must last several system clocks. The serial output is given as a data line with a separate output-enable. The output-enable is low whenever the line should be high-impedance. The protect bits are plain registers that keep their values from one chip-select frame to the next. They stand in for nonvolatile storage.

Top module: `spi_status_front`

## Requirements
- R1: After reset, a status read returns 0x00, and the output-enable is low while chip select is high.
- R2: A complete set-write-enable opcode (0x06) sets the write-enable latch, which reads as status bit 1.
- R3: A complete clear-write-enable opcode (0x04) clears the write-enable latch. Set and clear work whatever the protect-enable (bit 7) and block-protect bits hold.
- R4: A write-status frame (0x01 followed by one data byte) with the write-enable latch clear changes no status bit.
- R5: A write-status frame of exactly 16 clocks with the latch set copies data bits 7, 3 and 2 into status bits 7, 3 and 2 when chip select rises. Status bits 6 to 4 always read 0.
- R6: A successful status write holds the write-in-progress flag (status bit 0 and the `wip` port) high for exactly WR_CYCLES system clocks. When that cycle ends, the write-enable latch clears.
- R7: Status bit 0 and `wip` read 1 while `busy_in` is high. A read-status command is accepted at any time, including during a write cycle.
- R8: In a read-status frame, the output-enable stays low over the eight opcode clocks. The status then comes out most significant bit first, changing after the falling edges of clocks 7 to 14.
- R9: If clocking continues past 16 clocks in a read-status frame, a fresh snapshot of the status is sent on every further eight clocks.
- R10: Raising chip select in the middle of a byte has no effect: a partial set-enable opcode leaves the latch clear. A write-status frame of 15 or 17 clocks changes nothing.
- R11: Raising chip select returns the output-enable to low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, mode 0 |
| mosi | input | 1 | Serial data in, sampled on the rising sck edge |
| busy_in | input | 1 | Busy flag from the array write engine |
| miso | output | 1 | Serial data out, changes after the falling sck edge |
| miso_oe | output | 1 | Output enable for miso; low means high-impedance |
| wip | output | 1 | Write-in-progress flag |

## Verification
Every stored bit of this block can only be seen through a status read or on the `wip` pin. Suppose the write-enable latch or a protect bit holds a wrong value. It then shows up on the very next read-status frame, within sixteen serial clocks, as a wrong bit at its fixed position. A miscounted write-cycle timer shows up in the measured length of the `wip` pulse. A wrong frame counter shows up because an aborted or mis-sized frame alters the status. A fault in output-enable handling shows up during the opcode clocks, or right after chip select rises.

// File: rtl/spi_status_front.sv
module spi_status_front #(
  parameter int WR_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  input  logic busy_in,
  output logic miso,
  output logic miso_oe,
  output logic wip
);
  localparam int TW = $clog2(WR_CYCLES + 1);
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_WRSR = 8'h01;

  logic [2:0] sck_s, cs_s;
  logic [1:0] mosi_s;
  logic [2:0] bitc;
  logic [1:0] bytec;
  logic [7:0] sh_in, op, wr_data, sh_out;
  logic wel, wpen, bp1, bp0;
  logic [TW-1:0] timer;

  wire sck_rise = sck_s[1] & ~sck_s[2];
  wire sck_fall = ~sck_s[1] & sck_s[2];
  wire cs_act   = ~cs_s[1];
  wire cs_rise  = cs_s[1] & ~cs_s[2];
  wire [7:0] byte_in = {sh_in[6:0], mosi_s[1]};
  wire op_done  = cs_act & sck_rise & (bitc == 3'd7) & (bytec == 2'd0);
  wire tmr_on   = (timer != '0);
  wire [7:0] status = {wpen, 3'b000, bp1, bp0, wel, wip};
  wire wr_ok = cs_rise & (op == OP_WRSR) & (bytec == 2'd2) & (bitc == 3'd0) & wel;

  assign wip  = busy_in | tmr_on;
  assign miso = miso_oe & sh_out[7];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_s <= '0; cs_s <= '1; mosi_s <= '0;
    end else begin
      sck_s <= {sck_s[1:0], sck};
      cs_s <= {cs_s[1:0], cs_n};
      mosi_s <= {mosi_s[0], mosi};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bitc <= '0; bytec <= '0; sh_in <= '0; op <= '0; wr_data <= '0;
    end else if (!cs_act) begin
      bitc <= '0; bytec <= '0; op <= '0;
    end else if (sck_rise) begin
      sh_in <= byte_in;
      bitc <= bitc + 3'd1;
      if (bitc == 3'd7) begin
        if (bytec != 2'd3) bytec <= bytec + 2'd1;
        if (bytec == 2'd0) op <= byte_in;
        if (bytec == 2'd1) wr_data <= byte_in;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh_out <= '0; miso_oe <= 1'b0;
    end else if (!cs_act) begin
      miso_oe <= 1'b0;
    end else if (sck_fall && op == OP_RDSR && bytec != 2'd0) begin
      miso_oe <= 1'b1;
      sh_out <= (bitc == 3'd0) ? status : {sh_out[6:0], 1'b0};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wel <= 1'b0; wpen <= 1'b0; bp1 <= 1'b0; bp0 <= 1'b0; timer <= '0;
    end else begin
      if (wr_ok) begin
        wpen <= wr_data[7]; bp1 <= wr_data[3]; bp0 <= wr_data[2];
        timer <= TW'(WR_CYCLES);
      end else if (tmr_on) begin
        timer <= timer - 1'b1;
      end
      if (op_done && byte_in == OP_WREN) wel <= 1'b1;
      else if (op_done && byte_in == OP_WRDI) wel <= 1'b0;
      else if (timer == TW'(1)) wel <= 1'b0;
    end

  // R5
  prot_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable({wpen, bp1, bp0}));
  // R2
  wel_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(sck_rise));
  // R6
  wel_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tmr_on) |-> !wel);
  // R11
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s[1] && cs_s[2]) |=> !miso_oe);
  // R7
  wip_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_in) |=> wip);
endmodule

// File: tb/spi_status_front_bench.sv
module spi_status_front_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int WRC = 400;

  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, mosi = 0, busy_in = 0;
  logic miso, miso_oe, wip;
  int checks = 0, errors = 0;
  int run_len = 0, last_run = 0;
  logic [7:0] exp_st = 8'h00;

  spi_status_front #(.WR_CYCLES(WRC)) u_spi_status_front (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .busy_in(busy_in), .miso(miso), .miso_oe(miso_oe), .wip(wip));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (wip) run_len <= run_len + 1;
    else begin
      if (run_len != 0) last_run <= run_len;
      run_len <= 0;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [31:0] data, input int n,
                      output logic [31:0] rx, output int oe_bad);
    rx = '0; oe_bad = 0;
    cs_n = 0; waitc(HALF);
    for (int i = 0; i < n; i++) begin
      mosi = data[n-1-i];
      waitc(HALF); sck = 1;
      waitc(HALF); sck = 0;
      waitc(HALF);
      rx = {rx[30:0], miso};
      if (i < 7 && miso_oe) oe_bad++;
    end
    cs_n = 1; waitc(HALF);
    if (miso_oe) oe_bad++;
    waitc(HALF);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [31:0] rx; int ob;
    xfer({24'h0, op}, 8, rx, ob);
  endtask

  task automatic wrsr(input logic [7:0] d, input int n);
    logic [31:0] rx; int ob;
    xfer({16'h0, 8'h01, d} << (n - 16), n, rx, ob);
  endtask

  task automatic rdsr(input string req, input logic [7:0] exp);
    logic [31:0] rx; int ob;
    xfer(32'h05 << 8, 16, rx, ob);
    chk(req, rx[8:1], exp);
    chk("R8 oe during opcode/R11 after cs", ob, 0);
  endtask

  initial begin
    logic [31:0] rx; int ob;
    waitc(3); rst_n = 1; waitc(3);
    chk("R1 oe idle", miso_oe, 0);
    rdsr("R1 reset status", 8'h00);

    cmd(8'h06); exp_st = 8'h02;
    rdsr("R2 wren", exp_st);
    cmd(8'h04); exp_st = 8'h00;
    rdsr("R3 wrdi", exp_st);

    wrsr(8'hFC, 16);
    rdsr("R4 wrsr without wel", 8'h00);
    chk("R4 no wip", last_run, 0);

    cmd(8'h06);
    wrsr(8'hFC, 15);
    rdsr("R10 wrsr 15 clocks", 8'h02);
    wrsr(8'hFC, 17);
    rdsr("R10 wrsr 17 clocks", 8'h02);

    cmd(8'h04);
    xfer(32'h06 >> 3, 5, rx, ob);
    rdsr("R10 aborted wren", 8'h00);

    cmd(8'h06);
    wrsr(8'hFF, 16);
    rdsr("R7 read during write cycle R5", 8'h8F);
    chk("R6 wip pin during cycle", wip, 1);
    while (wip) waitc(1);
    waitc(2);
    chk("R6 wip length", last_run, WRC);
    rdsr("R6 wel cleared R5 bits 6-4 zero", 8'h8C);

    cmd(8'h06);
    rdsr("R3 wren with protection", 8'h8E);
    cmd(8'h04);
    rdsr("R3 wrdi with protection", 8'h8C);

    cmd(8'h06);
    wrsr(8'h08, 16);
    while (wip) waitc(1);
    waitc(2);
    rdsr("R5 second write", 8'h08);

    busy_in = 1; waitc(2);
    chk("R7 wip pin busy", wip, 1);
    rdsr("R7 busy status", 8'h09);

    cs_n = 0; waitc(HALF);
    for (int i = 0; i < 24; i++) begin
      mosi = (32'h05 << 16) >> (23 - i);
      waitc(HALF); sck = 1;
      waitc(HALF); sck = 0;
      waitc(HALF);
      rx = {rx[30:0], miso};
      if (i == 14) busy_in = 0;
    end
    cs_n = 1; waitc(HALF);
    chk("R11 oe after cs rise", miso_oe, 0);
    waitc(HALF);
    chk("R9 first byte", rx[16:9], 8'h09);
    chk("R9 repeat byte", rx[8:1], 8'h08);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule